// File: doc/BRIEF.md
# Scanline-Counting Interrupt Generator

This block counts scanline events from the video side. It raises a maskable, level-sensitive interrupt request to the CPU once a programmed number of events has passed. The CPU controls it through four write-only registers, selected by a coarse address decode. The registers are:

- a reload latch,
- a command that copies the latch into the counter,
- a command that disables the interrupt and acknowledges it,
- a command that enables the interrupt.

The counter is held as a signed value one bit wider than the data bus. A strobe that moves it from zero to minus one is the event that fires the interrupt. A counter that is already negative stays idle until software loads it again.

A disable command also arms a reset mode. While reset mode is set, a latch write loads the counter directly. The next scanline strobe clears reset mode. Outside reset mode, a latch write only marks the latch value as pending. The next enable command then applies that pending value.

Top module: `scanline_irq_gen`

## Requirements
- R1: A write takes effect only with `wr_en` high, and only address bits 15:13 and bit 0 select a register. Bits 15:13 = 110 with bit 0 = 0 selects the latch register, and bit 0 = 1 selects the reload command. Bits 15:13 = 111 with bit 0 = 0 selects the disable command, and bit 0 = 1 selects the enable command. Any other address has no effect.
- R2: After a synchronous reset (`rst_n` low at a clock edge), the counter, the latch, the enable, reset mode and the pending flag are all zero, and `irq` is low.
- R3: A latch write while reset mode is set stores the data in the latch, loads the counter with it and clears the pending flag.
- R4: A latch write while reset mode is clear stores the data in the latch and sets the pending flag, leaving the counter unchanged.
- R5: A reload command copies the latch into the counter.
- R6: A disable command clears the enable, drops `irq` after the clock edge that samples it, and sets reset mode.
- R7: An enable command sets the enable, and loads the counter from the latch when the pending flag is set.
- R8: A scanline strobe clears reset mode and decrements a non-negative counter. When the counter goes from 0 to -1 with the enable set, `irq` is high after that clock edge. A latch value of N therefore fires on the (N+1)-th strobe.
- R9: A strobe leaves a negative counter unchanged and does not raise `irq`.
- R10: Once high, `irq` stays high through strobes, reload and enable commands until a disable command is written.
- R11: A scanline strobe in a cycle where `wr_en` is high is dropped: it neither changes the counter nor clears reset mode.
- R12: A counter that passes below zero while disabled does not raise `irq`, and a later enable command does not raise it either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| line_strobe | input | 1 | One-cycle scanline event from the video side |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions take it that a CPU write lasts one cycle and that the scanline strobe is a single-cycle pulse. A strobe that overlaps a write is covered by a property of its own rather than assumed away. The stimulus keeps writes and strobes in separate cycles everywhere except in the one directed case for the collision rule. That case pairs a strobe with a write to an unmapped address, so only the dropping rule can explain the result.

// File: rtl/scanirq_pkg.sv
// Package: shared register-select type for the scanline interrupt generator.
// Assumes exactly four CPU-visible registers; SEL_NONE marks no access.
package scanirq_pkg;
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LATCH,
        SEL_RELOAD,
        SEL_OFF,
        SEL_ON
    } reg_sel_e;
endpackage

// File: rtl/scanirq_decode.sv
// Module: decodes a CPU write into one of four register selects and qualifies
// the scanline strobe. Assumes the select lives in the top three address bits
// and bit 0; every other address bit is masked out. A strobe arriving while a
// write is in progress is dropped.
module scanirq_decode
    import scanirq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              line_strobe,
    output reg_sel_e          sel,
    output logic              strobe_ok
);
    localparam logic [ADDR_W-1:0] DEC_MASK = {3'b111, {(ADDR_W-4){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] K_LATCH  = {3'b110, {(ADDR_W-4){1'b0}}, 1'b0};
    localparam logic [ADDR_W-1:0] K_RELOAD = {3'b110, {(ADDR_W-4){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] K_OFF    = {3'b111, {(ADDR_W-4){1'b0}}, 1'b0};
    localparam logic [ADDR_W-1:0] K_ON     = {3'b111, {(ADDR_W-4){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] key;

    // Purpose: reduce the address to its decoded bits and pick a register.
    always_comb begin
        key = wr_addr & DEC_MASK;
        sel = SEL_NONE;
        if (wr_en) begin
            unique case (key)
                K_LATCH:  sel = SEL_LATCH;
                K_RELOAD: sel = SEL_RELOAD;
                K_OFF:    sel = SEL_OFF;
                K_ON:     sel = SEL_ON;
                default:  sel = SEL_NONE;
            endcase
        end
    end

    // Purpose: a strobe counts only in a cycle free of CPU writes.
    assign strobe_ok = line_strobe && !wr_en;
endmodule

// File: rtl/scanirq_counter.sv
// Module: the reload latch, pending flag, reset-mode flag and the signed down
// counter. Assumes sel and strobe_ok are never both active (the decoder
// guarantees this). Emits a one-cycle fire pulse when the counter leaves zero.
module scanirq_counter
    import scanirq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  reg_sel_e                 sel,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     strobe_ok,
    output logic signed [DATA_W:0]   cnt,
    output logic                     rmode,
    output logic                     pending,
    output logic                     fire
);
    localparam int CNT_W = DATA_W + 1;

    logic [DATA_W-1:0]        latch_q;
    logic signed [CNT_W-1:0]  cnt_q;
    logic                     rmode_q;
    logic                     pend_q;

    // Purpose: a strobe that moves a zero counter to minus one fires.
    assign fire = strobe_ok && (cnt_q == '0);

    // Purpose: apply register commands and scanline decrements.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            cnt_q   <= '0;
            rmode_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            case (sel)
                SEL_LATCH: begin
                    latch_q <= wr_data;
                    if (rmode_q) begin
                        cnt_q  <= signed'({1'b0, wr_data});
                        pend_q <= 1'b0;
                    end else begin
                        pend_q <= 1'b1;
                    end
                end
                SEL_RELOAD: cnt_q <= signed'({1'b0, latch_q});
                SEL_OFF:    rmode_q <= 1'b1;
                SEL_ON: begin
                    if (pend_q) cnt_q <= signed'({1'b0, latch_q});
                end
                default: begin
                    if (strobe_ok) begin
                        rmode_q <= 1'b0;
                        if (!cnt_q[CNT_W-1]) cnt_q <= cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    assign cnt     = cnt_q;
    assign rmode   = rmode_q;
    assign pending = pend_q;
endmodule

// File: rtl/scanirq_flag.sv
// Module: interrupt enable and the sticky interrupt request. Assumes fire is a
// single-cycle pulse. The request is cleared only by the disable command.
module scanirq_flag
    import scanirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  reg_sel_e sel,
    input  logic     fire,
    output logic     en,
    output logic     irq
);
    // Purpose: track the enable and hold the request until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en  <= 1'b0;
            irq <= 1'b0;
        end else begin
            if (sel == SEL_OFF) begin
                en  <= 1'b0;
                irq <= 1'b0;
            end else if (sel == SEL_ON) begin
                en <= 1'b1;
            end
            if (fire && en) irq <= 1'b1;
        end
    end
endmodule

// File: rtl/scanline_irq_gen.sv
// Module: top of the scanline-counting interrupt generator. Wires the decoder,
// the counter and the interrupt flag. Assumes one-cycle CPU writes and a
// one-cycle scanline strobe, both synchronous to clk.
module scanline_irq_gen
    import scanirq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              line_strobe,
    output logic              irq
);
    reg_sel_e                sel;
    logic                    strobe_ok;
    logic signed [DATA_W:0]  cnt_q;
    logic                    rmode_q;
    logic                    pend_q;
    logic                    fire;
    logic                    en_q;

    scanirq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .line_strobe (line_strobe),
        .sel         (sel),
        .strobe_ok   (strobe_ok)
    );

    scanirq_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .wr_data   (wr_data),
        .strobe_ok (strobe_ok),
        .cnt       (cnt_q),
        .rmode     (rmode_q),
        .pending   (pend_q),
        .fire      (fire)
    );

    scanirq_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .fire  (fire),
        .en    (en_q),
        .irq   (irq)
    );
endmodule

// File: rtl/scanirq_checker.sv
// Module: property checker for scanline_irq_gen, bound to the top. Decodes
// addresses on its own from the port values.
module scanirq_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic [ADDR_W-1:0]       wr_addr,
    input logic [DATA_W-1:0]       wr_data,
    input logic                    line_strobe,
    input logic                    irq,
    input logic signed [DATA_W:0]  cnt,
    input logic                    en,
    input logic                    rmode,
    input logic                    pending
);
    logic hi_c, hi_e, lo;
    logic w_latch, w_off, w_none;

    // Purpose: independent decode of the written register.
    always_comb begin
        hi_c    = wr_addr[ADDR_W-1:ADDR_W-3] == 3'b110;
        hi_e    = wr_addr[ADDR_W-1:ADDR_W-3] == 3'b111;
        lo      = wr_addr[0];
        w_latch = wr_en && hi_c && !lo;
        w_off   = wr_en && hi_e && !lo;
        w_none  = wr_en && !hi_c && !hi_e;
    end

    p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(line_strobe) && ($past(cnt) == 0));

    p_off_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        w_off |=> !irq && rmode && !en);

    p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !w_off |=> irq);

    p_neg_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < 0 && !wr_en |=> $stable(cnt));

    p_direct_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        w_latch && rmode |=> (cnt == $signed({1'b0, $past(wr_data)})) && !pending);

    p_collide_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        w_none && line_strobe |=> $stable(cnt) && $stable(rmode));

    p_off_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !en && !irq |=> !irq);
endmodule

bind scanline_irq_gen scanirq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .line_strobe (line_strobe),
    .irq         (irq),
    .cnt         (cnt_q),
    .en          (en_q),
    .rmode       (rmode_q),
    .pending     (pend_q)
);

// File: tb/tb_scanline_irq_gen.sv
module tb_scanline_irq_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        line_strobe = 1'b0;
    logic        irq;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    scanline_irq_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .line_strobe(line_strobe), .irq(irq)
    );

    // Vectors: {latch register address alias, latch value}; fires on value+1 strobes.
    localparam logic [23:0] VEC [0:4] = '{
        24'hC000_00, 24'hC0FE_01, 24'hDFFE_05, 24'hC000_FF, 24'hCA02_02
    };

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            line_strobe = 1'b1;
            @(negedge clk);
            line_strobe = 1'b0;
        end
    endtask

    task automatic chk(input logic exp, input string req);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s irq=%0b expected %0b", req, irq, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog irq=%0b expected run to end", irq);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(1'b0, "R2 irq low after reset");
        // R2: counter reset to 0, so enable then one strobe fires.
        wr(16'hE001, 8'h00);
        chk(1'b0, "R7 enable alone no irq");
        strobe(1);
        chk(1'b1, "R2 zero counter fires on first strobe");
        // R10: request held through strobe, enable and reload.
        strobe(1); wr(16'hE001, 8'h00); wr(16'hC001, 8'h00);
        chk(1'b1, "R10 irq held");
        wr(16'hE000, 8'h00);
        chk(1'b0, "R6 disable clears irq");
        // R12: wrap while disabled, then pending latch applied by enable.
        wr(16'hC001, 8'h00);
        strobe(1);
        chk(1'b0, "R12 wrap while disabled");
        wr(16'hC000, 8'h03);
        wr(16'hE001, 8'h00);
        chk(1'b0, "R12 enable after wrap no irq");
        strobe(3);
        chk(1'b0, "R7 pending latch loaded, not yet fired");
        strobe(1);
        chk(1'b1, "R7 R4 pending latch fires on fourth strobe");
        // Vector loop: R3 direct load in reset mode, R8 fire timing.
        foreach (VEC[k]) begin
            wr(16'hE000, 8'h00);
            wr(VEC[k][23:8], VEC[k][7:0]);
            wr(16'hE001, 8'h00);
            strobe(int'(VEC[k][7:0]));
            chk(1'b0, $sformatf("R3 vector %0d before fire", k));
            strobe(1);
            chk(1'b1, $sformatf("R8 vector %0d fires", k));
        end
        // R9: negative counter idles.
        wr(16'hE000, 8'h00);
        chk(1'b0, "R6 disable after vectors");
        strobe(1);
        wr(16'hE001, 8'h00);
        strobe(5);
        chk(1'b0, "R9 negative counter idle");
        // R5: reload copies latch value 2.
        wr(16'hC001, 8'h00);
        strobe(2);
        chk(1'b0, "R5 reload before fire");
        strobe(1);
        chk(1'b1, "R5 reload fires on third strobe");
        // R4: latch write outside reset mode leaves the counter alone.
        wr(16'hE000, 8'h00);
        wr(16'hC000, 8'h04);
        wr(16'hE001, 8'h00);
        strobe(1);
        wr(16'hC000, 8'h0A);
        strobe(3);
        chk(1'b0, "R4 old count still running");
        strobe(1);
        chk(1'b1, "R4 fires on old count");
        // R1: unmapped addresses ignored, alias of disable works.
        wr(16'h6000, 8'h00);
        wr(16'hA001, 8'h00);
        chk(1'b1, "R1 unmapped writes ignored");
        wr(16'hF00E, 8'h00);
        chk(1'b0, "R1 disable alias decoded");
        // R11: strobe during a write is dropped.
        wr(16'hC000, 8'h00);
        wr(16'hE001, 8'h00);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 16'h0000; line_strobe = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; line_strobe = 1'b0;
        chk(1'b0, "R11 colliding strobe dropped");
        strobe(1);
        chk(1'b1, "R11 next strobe fires");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule